// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage of a sum-of-products programmable logic array. It holds `NUM_CELLS` identical macrocells. Each cell receives `TERMS` product terms from the array. Two global bits pick one of three architectures for the whole bank, and per-cell bits pick polarity and the cell's role. Each cell drives a pin value, a tristate enable for that pin, and a feedback bit that goes back into the array. Cell `i` takes its product terms from bits `i*TERMS` up to `i*TERMS+TERMS-1` of `pterm`. Term 0 is the lowest bit of that slice.

Each cell decodes its settings into one of five configuration states:
- `CFG_REGQ`: registered output.
- `CFG_COMB_IO`: combinational I/O with a product-term enable.
- `CFG_COMB_OUT`: combinational output that is always enabled.
- `CFG_DED_IN`: dedicated input.
- `CFG_OFF`: disabled.

The transitions between these states are purely combinational. They follow the mode bits and `ac1`:
- Registered architecture: `ac1`=0 gives `CFG_REGQ`, and `ac1`=1 gives `CFG_COMB_IO`.
- Complex architecture: every cell is `CFG_COMB_IO`.
- Simple architecture: `ac1`=0 gives `CFG_COMB_OUT`, and `ac1`=1 gives `CFG_DED_IN`. The two centre cells stay in `CFG_COMB_OUT` whatever `ac1` is.
- Unused code: every cell is `CFG_OFF`.

Each cell has one register, which is the only sequential state in the block. It holds the complement of the registered pin level. It loads on every clock edge, from either the product terms or the preload input.

Top module: `olmc_bank`

## Requirements
- R1: The architecture is set by `{syn, ac0}`. 2'b01 is registered, 2'b11 is complex, 2'b10 is simple, and 2'b00 is disabled.
- R2: In every combinational configuration, `pol`=1 drives the pin with the OR of the cell's terms, and `pol`=0 drives the complement of that OR.
- R3: Every cell's register loads on each rising clock edge in every mode. The stored pin level is the OR of all `TERMS` terms, passed through the polarity. A registered cell (registered mode, `ac1`=0) shows this level on `pin_out` after the edge. Its `pin_oe` is the inverse of `oe_n`.
- R4: A registered cell feeds back the pin level held in its register, whatever the state of `oe_n`.
- R5: When `preload_en` is high at a rising edge, each register takes `preload_val[i]` as its pin level. This takes priority over the product terms.
- R6: While `rst_n` is low, and until the next load, every register holds pin level 1 whatever `pol` is.
- R7: A combinational I/O cell (registered mode with `ac1`=1, or any cell in complex mode) behaves as follows:
  - `pin_oe` is term 0.
  - `pin_out` is the OR of terms 1 to `TERMS-1`, passed through the polarity.
  - `fb` is `pin_out` when the pin is enabled, and `pin_in` when it is not.
- R8: In complex mode, `ac1` has no effect, and cells 0 and `NUM_CELLS-1` return `fb`=0.
- R9: In simple mode with `ac1`=0, `pin_oe` is 1, `pin_out` is the OR of all terms passed through the polarity, and `fb` equals `pin_out`.
- R10: In simple mode with `ac1`=1, a cell becomes an input with `pin_oe`=0, `pin_out`=0 and `fb`=`pin_in`. The centre cells `NUM_CELLS/2-1` and `NUM_CELLS/2` ignore `ac1`, stay enabled outputs, and return `fb`=0.
- R11: In the disabled code, every cell drives `pin_oe`=0, `pin_out`=0 and `fb`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common register clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| syn | input | 1 | Global architecture bit, upper |
| ac0 | input | 1 | Global architecture bit, lower |
| ac1 | input | NUM_CELLS | Per-cell role select |
| pol | input | NUM_CELLS | Per-cell polarity, 1 = active high |
| pterm | input | NUM_CELLS*TERMS | Product terms, `TERMS` bits per cell |
| oe_n | input | 1 | Common output enable for registered cells, active low |
| preload_en | input | 1 | Synchronous register preload strobe |
| preload_val | input | NUM_CELLS | Pin levels to preload |
| pin_in | input | NUM_CELLS | Level seen on each pin from outside |
| pin_out | output | NUM_CELLS | Value each cell drives |
| pin_oe | output | NUM_CELLS | Tristate enable for each pin |
| fb | output | NUM_CELLS | Feedback bit to the array |

## Verification
The hardest case to reach is the registered path. There, the pin shows a level computed at the previous edge, while reset, preload, polarity changes and the common enable all compete for that register. A second hard case is a combinational I/O cell whose own term 0 tristates the pin, so that its feedback has to switch over to the external `pin_in`. The stimulus uses sparse product terms (four random words ANDed together), so each OR is 0 or 1 with similar likelihood. It interleaves preload strobes at random, and it asserts reset again in the middle of the run with the opposite polarity. A behavioural model in the bench, which keeps its own register levels, is compared against every output on every cycle.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

    typedef enum logic [1:0] {
        ARCH_OFF,
        ARCH_REG,
        ARCH_CPLX,
        ARCH_SIMPLE
    } arch_t;

    typedef enum logic [2:0] {
        CFG_OFF,
        CFG_REGQ,
        CFG_COMB_IO,
        CFG_COMB_OUT,
        CFG_DED_IN
    } cell_cfg_t;

endpackage

// File: rtl/olmc_mode_decode.sv
module olmc_mode_decode
    import olmc_pkg::*;
(
    input  logic  syn,
    input  logic  ac0,
    output arch_t arch
);

    always_comb begin
        unique case ({syn, ac0})
            2'b01:   arch = ARCH_REG;
            2'b11:   arch = ARCH_CPLX;
            2'b10:   arch = ARCH_SIMPLE;
            2'b00:   arch = ARCH_OFF;
            default: arch = ARCH_OFF;
        endcase
    end

endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
    import olmc_pkg::*;
#(
    parameter int TERMS     = 8,
    parameter bit IS_OUTER  = 1'b0,
    parameter bit IS_CENTRE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  arch_t            arch,
    input  logic             ac1,
    input  logic             pol,
    input  logic [TERMS-1:0] pt,
    input  logic             oe_n,
    input  logic             preload_en,
    input  logic             preload_val,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             fb
);

    // term 0 doubles as the enable term in I/O configurations
    localparam int OE_TERM = 0;
    localparam int SUM_LO  = OE_TERM + 1;

    cell_cfg_t cfg;
    logic      sum_all;
    logic      sum_io;
    logic      lvl_next;
    logic      q_inv;      // stores the complement of the pin level
    logic      drv;
    logic      en;

    assign sum_all  = |pt;
    assign sum_io   = |pt[TERMS-1:SUM_LO];
    assign lvl_next = pol ? sum_all : ~sum_all;

    // configuration decode
    always_comb begin
        unique case (arch)
            ARCH_REG:    cfg = ac1 ? CFG_COMB_IO : CFG_REGQ;
            ARCH_CPLX:   cfg = CFG_COMB_IO;
            ARCH_SIMPLE: cfg = (ac1 && !IS_CENTRE) ? CFG_DED_IN : CFG_COMB_OUT;
            ARCH_OFF:    cfg = CFG_OFF;
            default:     cfg = CFG_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_inv <= 1'b0;
        end else if (preload_en) begin
            q_inv <= ~preload_val;
        end else begin
            q_inv <= ~lvl_next;
        end
    end

    // outputs
    always_comb begin
        drv = 1'b0;
        en  = 1'b0;
        fb  = 1'b0;
        unique case (cfg)
            CFG_REGQ: begin
                drv = ~q_inv;
                en  = ~oe_n;
                fb  = ~q_inv;
            end
            CFG_COMB_IO: begin
                drv = pol ? sum_io : ~sum_io;
                en  = pt[OE_TERM];
                if (IS_OUTER && (arch == ARCH_CPLX)) begin
                    fb = 1'b0;
                end else begin
                    fb = en ? drv : pin_in;
                end
            end
            CFG_COMB_OUT: begin
                drv = pol ? sum_all : ~sum_all;
                en  = 1'b1;
                fb  = IS_CENTRE ? 1'b0 : drv;
            end
            CFG_DED_IN: begin
                fb = pin_in;
            end
            CFG_OFF: begin
                fb = 1'b0;
            end
            default: begin
                fb = 1'b0;
            end
        endcase
    end

    assign pin_out = drv;
    assign pin_oe  = en;

endmodule

// File: rtl/olmc_bank.sv
module olmc_bank
    import olmc_pkg::*;
#(
    parameter int NUM_CELLS = 8,
    parameter int TERMS     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       syn,
    input  logic                       ac0,
    input  logic [NUM_CELLS-1:0]       ac1,
    input  logic [NUM_CELLS-1:0]       pol,
    input  logic [NUM_CELLS*TERMS-1:0] pterm,
    input  logic                       oe_n,
    input  logic                       preload_en,
    input  logic [NUM_CELLS-1:0]       preload_val,
    input  logic [NUM_CELLS-1:0]       pin_in,
    output logic [NUM_CELLS-1:0]       pin_out,
    output logic [NUM_CELLS-1:0]       pin_oe,
    output logic [NUM_CELLS-1:0]       fb
);

    localparam int CENTRE_LO = NUM_CELLS / 2 - 1;
    localparam int CENTRE_HI = NUM_CELLS / 2;

    arch_t arch;

    olmc_mode_decode u_decode (
        .syn  (syn),
        .ac0  (ac0),
        .arch (arch)
    );

    for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
        localparam bit OUTER  = (g == 0) || (g == NUM_CELLS - 1);
        localparam bit CENTRE = (g == CENTRE_LO) || (g == CENTRE_HI);

        olmc_cell #(
            .TERMS     (TERMS),
            .IS_OUTER  (OUTER),
            .IS_CENTRE (CENTRE)
        ) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .arch        (arch),
            .ac1         (ac1[g]),
            .pol         (pol[g]),
            .pt          (pterm[g*TERMS +: TERMS]),
            .oe_n        (oe_n),
            .preload_en  (preload_en),
            .preload_val (preload_val[g]),
            .pin_in      (pin_in[g]),
            .pin_out     (pin_out[g]),
            .pin_oe      (pin_oe[g]),
            .fb          (fb[g])
        );
    end

endmodule

// File: rtl/olmc_bank_checker.sv
module olmc_bank_checker #(
    parameter int NUM_CELLS = 8,
    parameter int TERMS     = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       syn,
    input logic                       ac0,
    input logic [NUM_CELLS-1:0]       ac1,
    input logic [NUM_CELLS-1:0]       pol,
    input logic [NUM_CELLS*TERMS-1:0] pterm,
    input logic                       oe_n,
    input logic                       preload_en,
    input logic [NUM_CELLS-1:0]       preload_val,
    input logic [NUM_CELLS-1:0]       pin_in,
    input logic [NUM_CELLS-1:0]       pin_out,
    input logic [NUM_CELLS-1:0]       pin_oe,
    input logic [NUM_CELLS-1:0]       fb
);

    logic past_valid;
    logic seen_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    for (genvar g = 0; g < NUM_CELLS; g++) begin : g_chk
        localparam bit CENTRE = (g == NUM_CELLS/2 - 1) || (g == NUM_CELLS/2);
        logic [TERMS-1:0] pt_c;
        logic             reg_cell;
        logic             io_cell;
        assign pt_c     = pterm[g*TERMS +: TERMS];
        assign reg_cell = !syn && ac0 && !ac1[g];
        assign io_cell  = (syn && ac0) || (!syn && ac0 && ac1[g]);

        assert_reg_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (past_valid && reg_cell && $past(reg_cell) && !$past(preload_en))
            |-> (pin_out[g] == $past(pol[g] ? |pt_c : ~|pt_c)));

        assert_reg_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
            reg_cell |-> (pin_oe[g] == !oe_n));

        assert_reg_fb_R4: assert property (@(posedge clk) disable iff (!rst_n)
            reg_cell |-> (fb[g] == pin_out[g]));

        assert_preload_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (past_valid && reg_cell && $past(preload_en))
            |-> (pin_out[g] == $past(preload_val[g])));

        assert_reset_high_R6: assert property (@(posedge clk)
            (!rst_n && seen_rst && reg_cell) |-> pin_out[g]);

        assert_io_oe_term_R7: assert property (@(posedge clk) disable iff (!rst_n)
            io_cell |-> (pin_oe[g] == pt_c[0]));

        if (g == 0 || g == NUM_CELLS - 1) begin : g_outer
            assert_outer_nofb_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (syn && ac0) |-> (fb[g] == 1'b0));
        end

        assert_simple_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (syn && !ac0 && (!ac1[g] || CENTRE)) |-> pin_oe[g]);

        if (!CENTRE) begin : g_edge
            assert_ded_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (syn && !ac0 && ac1[g]) |-> (!pin_oe[g] && (fb[g] == pin_in[g])));
        end

        assert_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (!syn && !ac0) |-> (!pin_oe[g] && !fb[g] && !pin_out[g]));
    end

endmodule

bind olmc_bank olmc_bank_checker #(
    .NUM_CELLS (NUM_CELLS),
    .TERMS     (TERMS)
) u_olmc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .syn         (syn),
    .ac0         (ac0),
    .ac1         (ac1),
    .pol         (pol),
    .pterm       (pterm),
    .oe_n        (oe_n),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .pin_in      (pin_in),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .fb          (fb)
);

// File: tb/olmc_bank_bench.sv
`timescale 1ns/1ps
module olmc_bank_bench;

    localparam int N = 8;
    localparam int T = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           syn, ac0, oe_n, preload_en;
    logic [N-1:0]   ac1, pol, preload_val, pin_in;
    logic [N*T-1:0] pterm;
    logic [N-1:0]   pin_out, pin_oe, fb;

    int checks = 0;
    int fails  = 0;
    bit m_lvl [N];

    always #4 clk = ~clk;

    olmc_bank #(.NUM_CELLS(N), .TERMS(T)) u_olmc_bank (
        .clk(clk), .rst_n(rst_n), .syn(syn), .ac0(ac0), .ac1(ac1), .pol(pol),
        .pterm(pterm), .oe_n(oe_n), .preload_en(preload_en),
        .preload_val(preload_val), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
    );

    // behavioural register levels (R3 R5 R6)
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n)          m_lvl[i] = 1'b1;
            else if (preload_en) m_lvl[i] = preload_val[i];
            else                 m_lvl[i] = pol[i] ? (|pterm[i*T +: T]) : !(|pterm[i*T +: T]);
        end
    end

    task automatic check_vec(string tag, string name, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        logic [N-1:0] e_out, e_oe, e_fb;
        for (int i = 0; i < N; i++) begin
            bit s_all, s_io, t0, outer, centre, lvl;
            s_all  = |pterm[i*T +: T];
            s_io   = |pterm[i*T+1 +: T-1];
            t0     = pterm[i*T];
            outer  = (i == 0) || (i == N-1);
            centre = (i == N/2-1) || (i == N/2);
            lvl    = rst_n ? m_lvl[i] : 1'b1;
            e_out[i] = 0; e_oe[i] = 0; e_fb[i] = 0;
            if (!syn && ac0 && !ac1[i]) begin
                e_out[i] = lvl; e_oe[i] = !oe_n; e_fb[i] = lvl;
            end else if (ac0) begin
                e_out[i] = pol[i] ? s_io : !s_io;
                e_oe[i]  = t0;
                e_fb[i]  = (syn && outer) ? 1'b0 : (t0 ? e_out[i] : pin_in[i]);
            end else if (syn) begin
                if (ac1[i] && !centre) begin
                    e_fb[i] = pin_in[i];
                end else begin
                    e_out[i] = pol[i] ? s_all : !s_all;
                    e_oe[i]  = 1'b1;
                    e_fb[i]  = centre ? 1'b0 : e_out[i];
                end
            end
        end
        check_vec(tag, "pin_out", pin_out, e_out);
        check_vec(tag, "pin_oe",  pin_oe,  e_oe);
        check_vec(tag, "fb",      fb,      e_fb);
    endtask

    function automatic logic [N*T-1:0] sparse();
        logic [N*T-1:0] v;
        v = {$urandom, $urandom};
        for (int k = 0; k < 3; k++) v &= {$urandom, $urandom};
        return v;
    endfunction

    // ac1_sel: 0 = all zero, 1 = all one, 2 = random
    task automatic run(string tag, int n, logic s, logic a0, int ac1_sel, bit use_pre);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            compare(tag);
            syn = s; ac0 = a0;
            ac1 = (ac1_sel == 0) ? '0 : (ac1_sel == 1) ? '1 : N'($urandom);
            pterm       = sparse();
            oe_n        = 1'($urandom);
            pin_in      = N'($urandom);
            preload_val = N'($urandom);
            preload_en  = use_pre ? 1'($urandom) : 1'b0;
            if ((c % 7) == 3) pol = N'($urandom);
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; syn = 1'b0; ac0 = 1'b1; ac1 = '0; pol = 8'b1010_0110;
        pterm = '0; oe_n = 1'b0; preload_en = 1'b0; preload_val = '0; pin_in = '0;
        run("R6 reset state", 4, 1'b0, 1'b1, 0, 1'b0);
        rst_n = 1'b1;
        run("R1 R3 R4 registered", 40, 1'b0, 1'b1, 0, 1'b0);
        run("R7 registered io", 30, 1'b0, 1'b1, 2, 1'b0);
        run("R5 preload", 40, 1'b0, 1'b1, 2, 1'b1);
        run("R8 R7 complex", 40, 1'b1, 1'b1, 2, 1'b1);
        run("R9 R2 simple out", 30, 1'b1, 1'b0, 0, 1'b0);
        run("R10 simple input", 30, 1'b1, 1'b0, 1, 1'b0);
        run("R10 simple mixed", 30, 1'b1, 1'b0, 2, 1'b1);
        run("R11 disabled", 20, 1'b0, 1'b0, 2, 1'b1);
        // R2 directed: same terms under both polarities
        @(negedge clk); compare("R2 polarity");
        syn = 1'b1; ac0 = 1'b0; ac1 = '0; pterm = 64'h0000_0100_0000_0001; pol = '1;
        @(negedge clk); compare("R2 polarity high");
        pol = '0;
        @(negedge clk); compare("R2 polarity low");
        // R6 mid-run reset with inverted polarity, then registered again
        syn = 1'b0; ac0 = 1'b1; ac1 = '0; pol = ~pol; rst_n = 1'b0;
        run("R6 reset mid-run", 3, 1'b0, 1'b1, 0, 1'b0);
        rst_n = 1'b1;
        run("R3 R5 after reset", 30, 1'b0, 1'b1, 0, 1'b1);
        @(negedge clk); compare("R3 final");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule